// File: doc/BRIEF.md
# Triple-Buffer DMA Channel Sequencer

This block steers the packet byte stream of one DMA channel into system-memory buffers. Software gives it the upper address bits of a current buffer and of a next buffer. Each buffer starts on a 64 KB boundary and holds at most 64 KB. The block forms the low 16 address bits itself from a running byte offset. It decides when the current buffer is finished. At that point it retires the current buffer to the previous role, promotes the next buffer to current and records a 4-bit status for both roles. The retired buffer also raises a sticky flag, and the channel interrupt is the OR of the enabled flags.

A channel works in one of two modes. In single-packet mode every packet end finishes the buffer. In multi-packet mode the buffer finishes at the first packet end whose end offset reaches a programmed byte threshold. Packets are never split between buffers, so a packet that crosses the threshold runs on into slack space beyond it. In isochronous mode the packet ends come from a programmed packet length rather than from the stream's end marker. A sync-marked byte that arrives part way through a packet moves the write position forward to the next packet boundary. If a buffer finishes while no next buffer is armed, the block stops accepting bytes and reports an error. It resumes as soon as software supplies a next base.

Top module: `tbd_seq`

## Requirements
- R1: A written byte goes to address {current base, offset[15:0]}. The offset restarts at 0 when the current base is written and when the buffers rotate, and each accepted byte that does not start a realignment uses the previous offset plus one.
- R2: After a rotation, the upper address bits are exactly the value last written to the next-base register, whatever the old current base was.
- R3: chan_status[3:0] holds the current-buffer status and chan_status[11:8] holds the previous-buffer status. All other bits are 0. The codes are 0 idle, 1 active, 2 done, 3 done with overrun past the threshold, and 4 error with no next buffer armed. A rotation writes 2 or 3 to the previous field.
- R4: With cfg_multi=0, every packet end completes the buffer.
- R5: With cfg_multi=1, the buffer completes only at a packet end whose end offset (last byte offset + 1) is at least cfg_size. The code is 3 if the end offset is greater than cfg_size and 2 if it is equal.
- R6: A packet that crosses cfg_size keeps its whole length in the same buffer, at consecutive offsets.
- R7: With cfg_iso=1, s_last is ignored and a packet ends after cfg_iso_len bytes. A value of 0 means 256.
- R8: With cfg_iso=1, a byte with s_sync=1 that arrives while the packet count is non-zero is placed at the next packet boundary (packet start + packet length) and counts as the packet's first byte. Such a byte sets flag bit 3.
- R9: Writing next-base arms the next buffer. A rotation consumes it, and a second completion with nothing re-armed does not rotate.
- R10: A completion with no armed next buffer sets the current status to 4 and flag bit 2, and holds s_ready low. A later next-base write rotates to that base and puts the pending done code (2 or 3) into the previous status.
- R11: chan_flags are sticky. Bit 0 is set by a rotation, bit 1 by a completion with overrun, bit 2 by the no-next error and bit 3 by a realignment; bits 11:4 read 0. Writing 1 to a flag_clr bit clears that flag, and a set in the same cycle wins over the clear.
- R12: chan_irq is 1 when some flag is set and enabled. Enable bit i gates flag i for i < 6, and enable bit 6 gates flags 11:6.
- R13: After reset, s_ready, m_we, chan_status, chan_flags and chan_irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_multi | input | 1 | 1 selects multi-packet mode, 0 selects single-packet mode |
| cfg_iso | input | 1 | Isochronous length-based packet ends |
| cfg_iso_len | input | 8 | Isochronous packet length (0 means 256) |
| cfg_size | input | 17 | Buffer byte threshold, 1 to 65536 |
| cfg_irq_en | input | 7 | Interrupt enables |
| cur_base_we | input | 1 | Write strobe for the current base |
| next_base_we | input | 1 | Write strobe for the next base |
| base_wdata | input | 16 | Base value (upper address bits) |
| flag_clr | input | 12 | Write-one-to-clear for the flags |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of a packet (non-isochronous) |
| s_sync | input | 1 | Sync command on this byte (isochronous) |
| s_ready | output | 1 | Stream byte accepted when valid |
| m_we | output | 1 | Memory write strobe |
| m_addr | output | 32 | Memory byte address |
| m_data | output | 8 | Memory write data |
| chan_status | output | 16 | Current and previous buffer status |
| chan_flags | output | 12 | Sticky event flags |
| chan_irq | output | 1 | Channel interrupt |

## Verification
The hardest state to reach is the starved stall: a buffer must finish while the next buffer is not armed, and bytes must keep waiting at the stream while software arms it late. The stimulus first uses up the only armed buffer with a packet. It then finishes a second packet and holds s_valid high for several cycles with nothing armed. Only after that does it write the next base, and it checks that the pending code moves into the previous status. Mid-packet sync realignment and a packet that overruns the threshold are reached with short, hand-placed byte counts. The 256-byte packet length is reached with a zero length setting.

// File: rtl/tbd_pkg.sv
// Shared types for the triple-buffer sequencer.
// Assumes buffers are 64 KB aligned, so offsets carry 17 bits to hold slack overruns.
package tbd_pkg;
    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_ACTIVE   = 4'd1,
        ST_DONE     = 4'd2,
        ST_DONE_OVF = 4'd3,
        ST_ERR      = 4'd4
    } buf_st_t;

    localparam int OFF_W   = 17;
    localparam int FL_ROT  = 0;
    localparam int FL_OVF  = 1;
    localparam int FL_ERR  = 2;
    localparam int FL_ALGN = 3;
endpackage

// File: rtl/tbd_offset.sv
// Byte offset tracker: gives the in-buffer offset of the byte on the stream
// and finds packet ends (from s_last, or from the isochronous length).
// Assumes restart and beat are never used to realign the same byte twice.
module tbd_offset #(
    parameter int OFF_W = 17,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             beat,
    input  logic             iso,
    input  logic [LEN_W-1:0] iso_len,
    input  logic             s_last,
    input  logic             s_sync,
    output logic [OFF_W-1:0] byte_off,
    output logic [OFF_W-1:0] end_off,
    output logic             pkt_end,
    output logic             realign
);
    localparam logic [OFF_W-1:0] LEN_MAX = OFF_W'(1 << LEN_W);

    logic [OFF_W-1:0] pkt_base, pkt_cnt, len_eff, base_eff, cur_cnt;

    // Effective packet position for the byte now on the stream.
    always_comb begin
        len_eff  = (iso_len == '0) ? LEN_MAX : OFF_W'(iso_len);
        realign  = iso && s_sync && (pkt_cnt != '0);
        base_eff = realign ? (pkt_base + len_eff) : pkt_base;
        cur_cnt  = realign ? '0 : pkt_cnt;
        byte_off = base_eff + cur_cnt;
        end_off  = byte_off + OFF_W'(1);
        pkt_end  = iso ? ((cur_cnt + OFF_W'(1)) == len_eff) : s_last;
    end

    // Advance the packet start and count on every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pkt_base <= '0;
            pkt_cnt  <= '0;
        end else if (beat) begin
            if (pkt_end) begin
                pkt_base <= end_off;
                pkt_cnt  <= '0;
            end else begin
                pkt_base <= base_eff;
                pkt_cnt  <= cur_cnt + OFF_W'(1);
            end
        end
    end

    // Byte within a packet: the next position is one past this byte (R1).
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !restart) |=> ((pkt_base + pkt_cnt) == $past(end_off)));
endmodule

// File: rtl/tbd_ring.sv
// Buffer role ring: holds the current and next bases, decides completion,
// rotates next->current->previous, records status and stalls on a missing next.
// Assumes cfg_size lies between 1 and 65536.
module tbd_ring
    import tbd_pkg::*;
#(
    parameter int BASE_W = 16,
    parameter int OFF_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_we,
    input  logic              next_we,
    input  logic [BASE_W-1:0] wdata,
    input  logic              beat,
    input  logic              pkt_end,
    input  logic [OFF_W-1:0]  end_off,
    input  logic              multi,
    input  logic [OFF_W-1:0]  size,
    output logic [BASE_W-1:0] cur_base,
    output logic              ready,
    output logic [3:0]        cur_code,
    output logic [3:0]        prev_code,
    output logic              rotate,
    output logic              ovf_evt,
    output logic              err_evt
);
    buf_st_t           cur_st, prev_st, pend_st, done_code;
    logic [BASE_W-1:0] next_base;
    logic              next_vld, cmp, take, resume;

    // Completion decision and the rotation causes for this cycle.
    always_comb begin
        cmp       = beat && pkt_end && (!multi || (end_off >= size)) && !cur_we;
        done_code = (end_off > size) ? ST_DONE_OVF : ST_DONE;
        take      = cmp && next_vld;
        resume    = !cur_we && (cur_st == ST_ERR) && next_we;
        rotate    = take || resume;
        ovf_evt   = cmp && (done_code == ST_DONE_OVF);
        err_evt   = cmp && !next_vld;
        ready     = (cur_st == ST_ACTIVE);
        cur_code  = 4'(cur_st);
        prev_code = 4'(prev_st);
    end

    // Current/previous roles and their status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_base <= '0;
            cur_st   <= ST_IDLE;
            prev_st  <= ST_IDLE;
            pend_st  <= ST_IDLE;
        end else if (cur_we) begin
            cur_base <= wdata;
            cur_st   <= ST_ACTIVE;
        end else if (take) begin
            prev_st  <= done_code;
            cur_base <= next_base;
        end else if (err_evt) begin
            cur_st   <= ST_ERR;
            pend_st  <= done_code;
        end else if (resume) begin
            prev_st  <= pend_st;
            cur_base <= wdata;
            cur_st   <= ST_ACTIVE;
        end
    end

    // Next-buffer register and its armed bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_base <= '0;
            next_vld  <= 1'b0;
        end else if (next_we && !resume) begin
            next_base <= wdata;
            next_vld  <= 1'b1;
        end else if (take) begin
            next_vld  <= 1'b0;
        end
    end

    p_take_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cur_base == $past(next_base)));
    p_consume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !next_we) |=> !next_vld);
    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> (!ready && cur_st == ST_ERR));
    p_prev_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rotate |=> (prev_st == ST_DONE || prev_st == ST_DONE_OVF));
endmodule

// File: rtl/tbd_irq.sv
// Sticky event flags with write-one-to-clear and the enable-gated interrupt.
// Assumes EN_W <= FLAG_W; the top enable bit covers all remaining flags.
module tbd_irq #(
    parameter int FLAG_W = 12,
    parameter int EN_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set,
    input  logic [FLAG_W-1:0] clr,
    input  logic [EN_W-1:0]   en,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);
    logic [FLAG_W-1:0] mask;

    // Map the narrower enable group onto the flags.
    for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_mask
        localparam int IDX = (gi < EN_W - 1) ? gi : EN_W - 1;
        assign mask[gi] = en[IDX];
    end

    // Flags hold until cleared; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end

    assign irq = |(flags & mask);

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ($past(flags) & ~$past(clr))) == ($past(flags) & ~$past(clr))));
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/tbd_seq.sv
// Triple-buffer DMA channel sequencer top: joins offset tracking, the buffer
// ring and the interrupt flags, and forms the memory write port.
// Assumes one byte per cycle and 64 KB aligned buffers.
module tbd_seq
    import tbd_pkg::*;
#(
    parameter int BASE_W = 16,
    parameter int LEN_W  = 8,
    parameter int FLAG_W = 12,
    parameter int EN_W   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_multi,
    input  logic                 cfg_iso,
    input  logic [LEN_W-1:0]     cfg_iso_len,
    input  logic [OFF_W-1:0]     cfg_size,
    input  logic [EN_W-1:0]      cfg_irq_en,
    input  logic                 cur_base_we,
    input  logic                 next_base_we,
    input  logic [BASE_W-1:0]    base_wdata,
    input  logic [FLAG_W-1:0]    flag_clr,
    input  logic                 s_valid,
    input  logic [7:0]           s_data,
    input  logic                 s_last,
    input  logic                 s_sync,
    output logic                 s_ready,
    output logic                 m_we,
    output logic [BASE_W+15:0]   m_addr,
    output logic [7:0]           m_data,
    output logic [15:0]          chan_status,
    output logic [FLAG_W-1:0]    chan_flags,
    output logic                 chan_irq
);
    logic              beat, pkt_end, realign, rotate, ovf_evt, err_evt;
    logic [OFF_W-1:0]  byte_off, end_off;
    logic [BASE_W-1:0] cur_base;
    logic [3:0]        cur_code, prev_code;
    logic [FLAG_W-1:0] fset;

    assign beat = s_valid && s_ready;

    tbd_offset #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_off (
        .clk(clk), .rst_n(rst_n), .restart(cur_base_we || rotate), .beat(beat),
        .iso(cfg_iso), .iso_len(cfg_iso_len), .s_last(s_last), .s_sync(s_sync),
        .byte_off(byte_off), .end_off(end_off), .pkt_end(pkt_end), .realign(realign)
    );

    tbd_ring #(.BASE_W(BASE_W), .OFF_W(OFF_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .cur_we(cur_base_we), .next_we(next_base_we),
        .wdata(base_wdata), .beat(beat), .pkt_end(pkt_end), .end_off(end_off),
        .multi(cfg_multi), .size(cfg_size), .cur_base(cur_base), .ready(s_ready),
        .cur_code(cur_code), .prev_code(prev_code), .rotate(rotate),
        .ovf_evt(ovf_evt), .err_evt(err_evt)
    );

    // Collect flag events; unused flag positions stay zero.
    always_comb begin
        fset          = '0;
        fset[FL_ROT]  = rotate;
        fset[FL_OVF]  = ovf_evt;
        fset[FL_ERR]  = err_evt;
        fset[FL_ALGN] = beat && realign;
    end

    tbd_irq #(.FLAG_W(FLAG_W), .EN_W(EN_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(fset), .clr(flag_clr), .en(cfg_irq_en),
        .flags(chan_flags), .irq(chan_irq)
    );

    // Memory write port and status word.
    assign m_we        = beat;
    assign m_data      = s_data;
    assign m_addr      = {cur_base, byte_off[15:0]};
    assign chan_status = {4'h0, prev_code, 4'h0, cur_code};

    p_no_write_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_status[3:0] == 4'd4) |-> !m_we);
    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        chan_flags[FLAG_W-1:4] == '0);
endmodule

// File: tb/tbd_seq_test.sv
module tbd_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_multi = 0, cfg_iso = 0;
    logic [7:0] cfg_iso_len = 8'd4;
    logic [16:0] cfg_size = 17'd8;
    logic [6:0] cfg_irq_en = 7'h7F;
    logic cur_base_we = 0, next_base_we = 0;
    logic [15:0] base_wdata = '0;
    logic [11:0] flag_clr = '0;
    logic s_valid = 0, s_last = 0, s_sync = 0;
    logic [7:0] s_data = '0;
    logic s_ready, m_we, chan_irq;
    logic [31:0] m_addr;
    logic [7:0] m_data;
    logic [15:0] chan_status;
    logic [11:0] chan_flags;

    int checks = 0, errors = 0;
    string tag = "R13";
    bit finished = 0;

    always #5 clk = ~clk;

    tbd_seq uut (.*);

    // Behavioural reference state.
    int cb = 0, nb = 0, nv = 0, cs = 0, ps = 0, pend = 0, pb = 0, cnt = 0;
    bit [11:0] fl = '0;
    int e_off, e_end, e_real, e_cmp, e_code, e_beat, e_ready;

    task automatic evaluate();
        int len, base_e, cc, eoff;
        len    = (cfg_iso_len == 0) ? 256 : int'(cfg_iso_len);
        e_ready = (cs == 1);
        e_beat = s_valid && e_ready;
        e_real = cfg_iso && s_sync && (cnt != 0);
        base_e = e_real ? pb + len : pb;
        cc     = e_real ? 0 : cnt;
        e_off  = base_e + cc;
        eoff   = e_off + 1;
        e_end  = cfg_iso ? (cc + 1 == len) : s_last;
        e_cmp  = e_beat && e_end && (!cfg_multi || eoff >= int'(cfg_size)) && !cur_base_we;
        e_code = (eoff > int'(cfg_size)) ? 3 : 2;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            cb = 0; nb = 0; nv = 0; cs = 0; ps = 0; pend = 0; pb = 0; cnt = 0; fl = '0;
        end else begin
            int rot, err, res, tk;
            bit [11:0] st;
            evaluate();
            rot = 0; err = 0; res = 0;
            tk = e_cmp && nv;
            if (cur_base_we) begin cb = base_wdata; cs = 1; end
            else if (tk) begin ps = e_code; cb = nb; rot = 1; end
            else if (e_cmp) begin cs = 4; pend = e_code; err = 1; end
            else if (cs == 4 && next_base_we) begin ps = pend; cb = base_wdata; cs = 1; rot = 1; res = 1; end
            if (next_base_we && !res) begin nb = base_wdata; nv = 1; end
            else if (tk) nv = 0;
            if (cur_base_we || rot) begin pb = 0; cnt = 0; end
            else if (e_beat) begin
                if (e_end) begin pb = e_off + 1; cnt = 0; end
                else begin pb = e_off - (e_real ? 0 : cnt); cnt = (e_real ? 0 : cnt) + 1; end
            end
            st = '0;
            st[0] = rot[0];
            st[1] = e_cmp && e_code == 3;
            st[2] = err[0];
            st[3] = e_beat && e_real;
            fl = (fl & ~flag_clr) | st;
        end
    end

    task automatic chk(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        bit [11:0] msk;
        bit eirq;
        if (!finished) begin
            evaluate();
            for (int i = 0; i < 12; i++) msk[i] = cfg_irq_en[(i < 6) ? i : 6];
            eirq = |(fl & msk);
            chk(s_ready === e_ready[0], "R10 s_ready", s_ready, e_ready);
            chk(m_we === e_beat[0], "R1 m_we", m_we, e_beat);
            if (e_beat) chk(m_addr === ((32'(cb) << 16) | 32'(e_off & 16'hFFFF)),
                            "R1 m_addr", m_addr, (32'(cb) << 16) | 32'(e_off & 16'hFFFF));
            chk(chan_status === 16'((ps << 8) | cs), "R3 status", chan_status, (ps << 8) | cs);
            chk(chan_flags === fl, "R11 flags", chan_flags, fl);
            chk(chan_irq === eirq, "R12 irq", chan_irq, eirq);
        end
    end

    task automatic step(); @(posedge clk); #1; endtask
    task automatic wr_cur(input logic [15:0] v);
        cur_base_we = 1; base_wdata = v; step(); cur_base_we = 0;
    endtask
    task automatic wr_next(input logic [15:0] v);
        next_base_we = 1; base_wdata = v; step(); next_base_we = 0;
    endtask
    task automatic put(input logic [7:0] d, input bit last, input bit sync);
        bit acc;
        s_valid = 1; s_data = d; s_last = last; s_sync = sync;
        do begin @(negedge clk); acc = s_ready; @(posedge clk); #1; end while (!acc);
        s_valid = 0; s_last = 0; s_sync = 0;
    endtask
    task automatic pkt(input int n);
        for (int i = 0; i < n; i++) put(8'(i), i == n - 1, 0);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog act=hung exp=done");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        tag = "R1";  wr_cur(16'h0012);
        tag = "R9";  wr_next(16'h0A40);
        tag = "R4";  pkt(3);
        tag = "R2";  pkt(2);
        tag = "R10"; s_valid = 1; s_data = 8'h55; repeat (3) step();
        wr_next(16'h7701); s_last = 1; step(); s_valid = 0; s_last = 0;
        repeat (2) step(); wr_next(16'h0B00); step();
        tag = "R11"; flag_clr = 12'h00F; step(); flag_clr = 0;
        wr_next(16'h0C00); pkt(1); flag_clr = 12'h001; put(8'h1, 1, 0); flag_clr = 0;
        step();
        tag = "R12"; cfg_irq_en = 7'h00; step(); cfg_irq_en = 7'h40; step();
        cfg_irq_en = 7'h01; step(); cfg_irq_en = 7'h7F;
        tag = "R1";  wr_cur(16'h2222); pkt(2); wr_cur(16'h2223); pkt(2);
        tag = "R5";  cfg_multi = 1; cfg_size = 17'd8;
        wr_next(16'h0D00); pkt(3); pkt(3); pkt(3);
        wr_next(16'h0E00); pkt(4); pkt(4);
        tag = "R6";  cfg_size = 17'd4; wr_next(16'h0F00); pkt(10);
        tag = "R7";  cfg_iso = 1; cfg_iso_len = 8'd4; cfg_size = 17'd12;
        wr_next(16'h1100); for (int i = 0; i < 12; i++) put(8'(i), i == 3, 0);
        tag = "R8";  wr_next(16'h1200); put(8'h1, 0, 0); put(8'h2, 0, 0); put(8'h3, 0, 1);
        for (int i = 0; i < 7; i++) put(8'(i), 0, 0);
        tag = "R7";  cfg_iso_len = 8'd0; cfg_size = 17'd300; wr_next(16'h1300);
        for (int i = 0; i < 512; i++) put(8'(i), 0, 0);
        tag = "R4";  cfg_multi = 0; cfg_iso_len = 8'd3; wr_next(16'h1400);
        for (int i = 0; i < 3; i++) put(8'(i), 0, 0);
        tag = "R13"; rst_n = 0; step(); step(); rst_n = 1; step();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule